// File: doc/BRIEF.md
# Set-Associative Read Cache with LRU Replacement

This block is a read-only cache between a load port and a memory that refills whole lines. A byte address is divided into a tag in the upper bits, a set index in the middle and a block offset in the low bits. The number of sets and the number of ways are both parameters. With one set the index field disappears and the tag covers every bit above the offset, so the cache is fully associative. With several sets and two ways it becomes a conventional two-way cache.

Each load request compares the tags of every way in its set at the same time. On a hit the matching line returns the byte chosen by the offset one cycle later, and memory is not involved. On a miss the block asks memory for the line, waits for the refill and writes it into the set. It uses an empty way if the set has one. Otherwise it replaces the way that was used least recently. A one-cycle response pulse carries the byte and a hit flag. Two counters record hits and misses.

Top module: `cache_rd_lru`

## Requirements
- R1: After reset every line is invalid, both counters read zero, `rsp_valid` and `mem_req_valid` are low and `req_ready` is high. The first load of any address after reset is therefore a miss.
- R2: The address splits into an offset (bits `OFFSET_W-1:0`), a set index of log2(`NUM_SETS`) bits directly above it, and a tag made of the remaining upper bits. Lines in different sets never displace one another.
- R3: A load hits when a valid way of its set holds a matching tag. The response then has `rsp_hit`=1, `rsp_data` equal to byte `offset` of the stored line (byte 0 in bits 7:0), and no memory request is made.
- R4: A load that misses raises `mem_req_valid` with `mem_req_addr` = address >> `OFFSET_W` and holds both until `mem_rsp_valid`. The response follows with `rsp_hit`=0 and the selected byte of the returned line.
- R5: A miss never replaces a valid line while its set still holds an invalid way.
- R6: When the set is full, a miss replaces the least-recently-used way. Every hit and every fill makes the touched way the most recently used one in its set. Just after reset way 0 is the first victim.
- R7: With 1 set of 4 ways, 2-byte lines and a 5-bit address, the load sequence 1,5,1,4,0,12,5,12,5,12,5 yields M,M,H,H,H,M,H,H,H,H,H.
- R8: With 2 sets of 2 ways on the same geometry, the same sequence yields M,M,H,H,H,M,M,H,H,H,H.
- R9: `hit_count` and `miss_count` each increase by exactly one in the cycle that a response of their kind is presented.
- R10: `req_ready` is low while a refill is outstanding, and each accepted load produces exactly one `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can accept a load |
| req_addr | input | ADDR_W | Byte address of the load |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Response came from a hit |
| rsp_data | output | BYTE_W | Loaded byte |
| mem_req_valid | output | 1 | Refill request outstanding |
| mem_req_addr | output | ADDR_W-OFFSET_W | Line address to refill |
| mem_rsp_valid | input | 1 | Refill line present |
| mem_rsp_line | input | BYTE_W<<OFFSET_W | Refill line, byte 0 in the low bits |
| hit_count | output | CNT_W | Number of hits served |
| miss_count | output | CNT_W | Number of misses served |

## Verification
The cycle in which a refill returns does two things to one set on the same edge. It writes the new line into the chosen way, and it ages the LRU ranks of every other way in that set. A wrong victim or a wrong ageing shows up only later, as a changed hit/miss pattern. The bench therefore fills sets completely, touches ways in a known order, forces conflict misses, and judges each refill by which of the earlier lines still hit afterwards. It also runs the two fixed traces against a two-way instance and a fully associative instance and compares each outcome in the sequence.

// File: rtl/cache_rd_pkg.sv
// Package: shared types and helpers for the read cache.
// Assumes: parameters that count ways or sets are at least 1.
package cache_rd_pkg;

    // Controller state: accepting loads, or waiting for a line refill.
    typedef enum logic {
        CTL_IDLE   = 1'b0,
        CTL_REFILL = 1'b1
    } ctl_state_t;

    // Width of an index over n items; never less than one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cache_tag_store.sv
// Module: cache_tag_store
// Holds the valid bits, tags and lines of every way. It compares all ways of
// one set in parallel, reports the lowest invalid way of that set, and writes
// a refilled line.
// Assumes: at most one way per set ever holds a given tag; the fill port
// writes a tag that is absent from the set.
module cache_tag_store
    import cache_rd_pkg::*;
#(
    parameter int unsigned NUM_SETS = 2,
    parameter int unsigned NUM_WAYS = 2,
    parameter int unsigned TAG_W    = 3,
    parameter int unsigned LINE_W   = 16,
    localparam int unsigned IDX_W   = idx_bits(NUM_SETS),
    localparam int unsigned WAY_W   = idx_bits(NUM_WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  look_idx,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [LINE_W-1:0] hit_line,
    output logic              free_found,
    output logic [WAY_W-1:0]  free_way,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line
);

    logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
    logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];
    logic [LINE_W-1:0]   line_q  [NUM_SETS][NUM_WAYS];
    logic [NUM_WAYS-1:0] match;

    // One comparator per way of the looked-up set.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[look_idx][w] && (tag_q[look_idx][w] == look_tag);
    end

    // Pick the matching way and its line; the lowest index wins.
    always_comb begin
        hit      = |match;
        hit_way  = '0;
        hit_line = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_way  = WAY_W'(w);
                hit_line = line_q[look_idx][w];
            end
        end
    end

    // Find the lowest-numbered invalid way of the looked-up set.
    always_comb begin
        free_found = ~&valid_q[look_idx];
        free_way   = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid_q[look_idx][w]) free_way = WAY_W'(w);
        end
    end

    // Valid bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) valid_q[s] <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx][fill_way] <= 1'b1;
        end
    end

    // Tag and line storage: written on a fill, no reset needed.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx][fill_way]  <= fill_tag;
            line_q[fill_idx][fill_way] <= fill_line;
        end
    end

    // Never two matching ways in one set.
    assert_one_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1);

    // A fill into a set that still has an empty way must not overwrite a valid line.
    assert_fill_free_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(&valid_q[fill_idx])) |-> !valid_q[fill_idx][fill_way]);

endmodule

// File: rtl/cache_lru.sv
// Module: cache_lru
// Keeps a true-LRU rank per way in every set (0 = most recent,
// NUM_WAYS-1 = least recent) and names the victim of the looked-up set.
// Assumes: the ranks within a set always form a permutation; touch_way
// belongs to the set given by look_idx.
module cache_lru
    import cache_rd_pkg::*;
#(
    parameter int unsigned NUM_SETS = 2,
    parameter int unsigned NUM_WAYS = 2,
    localparam int unsigned IDX_W   = idx_bits(NUM_SETS),
    localparam int unsigned WAY_W   = idx_bits(NUM_WAYS),
    localparam int unsigned AGE_W   = idx_bits(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    output logic [WAY_W-1:0] victim_way,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way
);

    logic [AGE_W-1:0]    age_q     [NUM_SETS][NUM_WAYS];
    logic [NUM_WAYS-1:0] rank_seen [NUM_SETS];

    // Reset ranks so way 0 is oldest; a touch makes one way newest and ages the younger ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int w = 0; w < NUM_WAYS; w++)
                    age_q[s][w] <= AGE_W'(NUM_WAYS - 1 - w);
        end else if (touch_en) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[look_idx][w] <= '0;
                else if (age_q[look_idx][w] < age_q[look_idx][touch_way])
                    age_q[look_idx][w] <= age_q[look_idx][w] + 1'b1;
            end
        end
    end

    // The victim is the way holding the oldest rank.
    always_comb begin
        victim_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (age_q[look_idx][w] == AGE_W'(NUM_WAYS - 1)) victim_way = WAY_W'(w);
        end
    end

    // Gather which ranks are present in each set, for the permutation check.
    always_comb begin
        for (int s = 0; s < NUM_SETS; s++) begin
            rank_seen[s] = '0;
            for (int w = 0; w < NUM_WAYS; w++) rank_seen[s][age_q[s][w]] = 1'b1;
        end
    end

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_chk
        // Every rank appears exactly once in each set.
        assert_age_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rank_seen[s] == {NUM_WAYS{1'b1}});
    end

endmodule

// File: rtl/cache_rd_lru.sv
// Module: cache_rd_lru
// Read-only cache with NUM_SETS sets of NUM_WAYS ways and true-LRU
// replacement. A hit answers one cycle after acceptance. A miss requests the
// line, fills it when it returns and answers in the cycle after the fill.
// Assumes: the memory holds mem_req_addr stable in its view and answers each
// request exactly once with mem_rsp_valid; NUM_SETS is a power of two.
module cache_rd_lru
    import cache_rd_pkg::*;
#(
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned OFFSET_W = 1,
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned NUM_SETS = 2,
    parameter int unsigned NUM_WAYS = 2,
    parameter int unsigned CNT_W    = 16,
    localparam int unsigned SET_BITS = $clog2(NUM_SETS),
    localparam int unsigned IDX_W    = idx_bits(NUM_SETS),
    localparam int unsigned WAY_W    = idx_bits(NUM_WAYS),
    localparam int unsigned TAG_W    = ADDR_W - OFFSET_W - SET_BITS,
    localparam int unsigned LINE_W   = BYTE_W << OFFSET_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    output logic                       rsp_valid,
    output logic                       rsp_hit,
    output logic [BYTE_W-1:0]          rsp_data,
    output logic                       mem_req_valid,
    output logic [ADDR_W-OFFSET_W-1:0] mem_req_addr,
    input  logic                       mem_rsp_valid,
    input  logic [LINE_W-1:0]          mem_rsp_line,
    output logic [CNT_W-1:0]           hit_count,
    output logic [CNT_W-1:0]           miss_count
);

    ctl_state_t           state_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [IDX_W-1:0]     req_idx, held_idx, look_idx;
    logic [TAG_W-1:0]     req_tag, held_tag;
    logic [OFFSET_W-1:0]  req_off, held_off;
    logic                 hit;
    logic [WAY_W-1:0]     hit_way, free_way, victim_way, fill_way, touch_way;
    logic [LINE_W-1:0]    hit_line;
    logic                 free_found, fill_en, accept, touch_en;

    // Pick one byte of a line by its offset.
    function automatic logic [BYTE_W-1:0] pick_byte(input logic [LINE_W-1:0] line,
                                                   input logic [OFFSET_W-1:0] off);
        return line[int'(off) * BYTE_W +: BYTE_W];
    endfunction

    // Address fields of the incoming and the held request.
    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign held_tag = addr_q[ADDR_W-1 -: TAG_W];
    assign req_off  = req_addr[OFFSET_W-1:0];
    assign held_off = addr_q[OFFSET_W-1:0];
    if (SET_BITS > 0) begin : g_idx
        assign req_idx  = req_addr[OFFSET_W +: SET_BITS];
        assign held_idx = addr_q[OFFSET_W +: SET_BITS];
    end else begin : g_noidx
        assign req_idx  = '0;
        assign held_idx = '0;
    end

    // While idle, look at the incoming set; during a refill, look at the held set.
    assign look_idx  = (state_q == CTL_IDLE) ? req_idx : held_idx;
    assign req_ready = (state_q == CTL_IDLE);
    assign accept    = req_valid && req_ready;
    assign fill_en   = (state_q == CTL_REFILL) && mem_rsp_valid;
    assign fill_way  = free_found ? free_way : victim_way;
    assign touch_en  = (accept && hit) || fill_en;
    assign touch_way = fill_en ? fill_way : hit_way;
    assign mem_req_valid = (state_q == CTL_REFILL);
    assign mem_req_addr  = addr_q[ADDR_W-1:OFFSET_W];

    cache_tag_store #(
        .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n),
        .look_idx(look_idx), .look_tag(req_tag),
        .hit(hit), .hit_way(hit_way), .hit_line(hit_line),
        .free_found(free_found), .free_way(free_way),
        .fill_en(fill_en), .fill_idx(held_idx), .fill_way(fill_way),
        .fill_tag(held_tag), .fill_line(mem_rsp_line)
    );

    cache_lru #(
        .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)
    ) u_lru (
        .clk(clk), .rst_n(rst_n),
        .look_idx(look_idx), .victim_way(victim_way),
        .touch_en(touch_en), .touch_way(touch_way)
    );

    // Controller: serve hits at once, park misses until the refill arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= CTL_IDLE;
            addr_q     <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_data   <= '0;
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                addr_q <= req_addr;
                if (hit) begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b1;
                    rsp_data  <= pick_byte(hit_line, req_off);
                    hit_count <= hit_count + 1'b1;
                end else begin
                    state_q <= CTL_REFILL;
                end
            end else if (fill_en) begin
                state_q    <= CTL_IDLE;
                rsp_valid  <= 1'b1;
                rsp_hit    <= 1'b0;
                rsp_data   <= pick_byte(mem_rsp_line, held_off);
                miss_count <= miss_count + 1'b1;
            end
        end
    end

    // A refill request stays up, with the same line address, until answered.
    assert_refill_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    // A hit response never coincides with an outstanding refill.
    assert_hit_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !mem_req_valid);

    // No response while the block is refusing loads.
    assert_busy_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !rsp_valid);

    // Each response advances the counters by exactly one in total.
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (CNT_W'(hit_count + miss_count) ==
                       CNT_W'($past(hit_count) + $past(miss_count) + 1'b1)));

endmodule

// File: tb/cache_rd_lru_bench.sv
`timescale 1ns/1ps
module cache_rd_lru_bench;

    localparam int ADDR_W = 5;
    localparam int OFF_W  = 1;
    localparam int LINE_W = 16;
    localparam int NVEC   = 22;

    // Vector: {instance select (1 = fully associative), address[4:0], expected hit}.
    localparam logic [6:0] VEC [NVEC] = '{
        {1'b1, 5'd1,  1'b0}, {1'b1, 5'd5,  1'b0}, {1'b1, 5'd1,  1'b1}, {1'b1, 5'd4,  1'b1},
        {1'b1, 5'd0,  1'b1}, {1'b1, 5'd12, 1'b0}, {1'b1, 5'd5,  1'b1}, {1'b1, 5'd12, 1'b1},
        {1'b1, 5'd5,  1'b1}, {1'b1, 5'd12, 1'b1}, {1'b1, 5'd5,  1'b1},
        {1'b0, 5'd1,  1'b0}, {1'b0, 5'd5,  1'b0}, {1'b0, 5'd1,  1'b1}, {1'b0, 5'd4,  1'b1},
        {1'b0, 5'd0,  1'b1}, {1'b0, 5'd12, 1'b0}, {1'b0, 5'd5,  1'b0}, {1'b0, 5'd12, 1'b1},
        {1'b0, 5'd5,  1'b1}, {1'b0, 5'd12, 1'b1}, {1'b0, 5'd5,  1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              rv [2];
    logic [ADDR_W-1:0] ra [2];
    logic              mrv [2];
    logic [LINE_W-1:0] mline [2];
    logic              rdy [2], sv [2], sh [2], mqv [2];
    logic [7:0]        sd [2];
    logic [ADDR_W-OFF_W-1:0] mqa [2];
    logic [15:0]       hc [2], mc [2];

    int checks = 0;
    int errors = 0;

    // Instance 0: 2 sets x 2 ways (defaults).
    cache_rd_lru u_cache_rd_lru (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_ready(rdy[0]), .req_addr(ra[0]),
        .rsp_valid(sv[0]), .rsp_hit(sh[0]), .rsp_data(sd[0]),
        .mem_req_valid(mqv[0]), .mem_req_addr(mqa[0]),
        .mem_rsp_valid(mrv[0]), .mem_rsp_line(mline[0]),
        .hit_count(hc[0]), .miss_count(mc[0])
    );

    // Instance 1: 1 set x 4 ways (fully associative).
    cache_rd_lru #(.NUM_SETS(1), .NUM_WAYS(4)) u_cache_rd_lru_fa (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_ready(rdy[1]), .req_addr(ra[1]),
        .rsp_valid(sv[1]), .rsp_hit(sh[1]), .rsp_data(sd[1]),
        .mem_req_valid(mqv[1]), .mem_req_addr(mqa[1]),
        .mem_rsp_valid(mrv[1]), .mem_rsp_line(mline[1]),
        .hit_count(hc[1]), .miss_count(mc[1])
    );

    // Memory contents: byte at address a.
    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // Memory models: answer each refill request one cycle later.
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            mrv[i]   <= mqv[i] && !mrv[i];
            mline[i] <= {mem_byte(2 * int'(mqa[i]) + 1), mem_byte(2 * int'(mqa[i]))};
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One load: drive for one cycle, check the port behaviour, wait for the response.
    task automatic do_load(input int s, input int a, input bit exp_hit, input string req);
        int n;
        @(negedge clk);
        rv[s] = 1'b1;
        ra[s] = ADDR_W'(a);
        @(negedge clk);
        rv[s] = 1'b0;
        if (exp_hit) begin
            check(!mqv[s], {req, " R3 no refill on hit"}, int'(mqv[s]), 0);
        end else begin
            check(mqv[s] && int'(mqa[s]) == (a >> OFF_W), {req, " R4 refill line address"},
                  int'(mqa[s]), a >> OFF_W);
            check(!rdy[s], {req, " R10 busy during refill"}, int'(rdy[s]), 0);
        end
        n = 0;
        while (!sv[s] && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(sv[s] && sh[s] == exp_hit, {req, " hit flag"}, int'(sv[s]) * 2 + int'(sh[s]),
              2 + int'(exp_hit));
        check(sd[s] == mem_byte(a), {req, " R3/R4 data byte"}, int'(sd[s]), int'(mem_byte(a)));
        @(negedge clk);
        check(!sv[s], {req, " R10 single pulse"}, int'(sv[s]), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            rv[i] = 1'b0;
            ra[i] = '0;
        end
        do_reset();
        // R1: reset state at the ports.
        for (int i = 0; i < 2; i++) begin
            check(!sv[i] && !mqv[i] && rdy[i], "R1 idle outputs", int'(sv[i]) + int'(mqv[i]), 0);
            check(hc[i] == 0 && mc[i] == 0, "R1 counters zero", int'(hc[i] + mc[i]), 0);
        end

        // R7 and R8: fixed traces walked from the vector table.
        for (int v = 0; v < NVEC; v++) begin
            do_load(int'(VEC[v][6]), int'(VEC[v][5:1]), VEC[v][0],
                    VEC[v][6] ? "R7 trace" : "R8 trace");
        end
        // R9: counters after the traces.
        check(hc[1] == 8 && mc[1] == 3, "R9 counters FA", int'(hc[1]) * 100 + int'(mc[1]), 803);
        check(hc[0] == 7 && mc[0] == 4, "R9 counters 2-way", int'(hc[0]) * 100 + int'(mc[0]), 704);

        // R1: reset mid-run clears lines and counters.
        do_reset();
        check(hc[0] == 0 && mc[0] == 0, "R1 counters cleared", int'(hc[0] + mc[0]), 0);
        do_load(0, 1, 1'b0, "R1 line invalid after reset");
        check(mc[0] == 1 && hc[0] == 0, "R9 one miss counted", int'(mc[0]), 1);

        // R2 and R6 on the 2-way instance.
        do_reset();
        do_load(0, 0, 1'b0, "R2 fill set0 tag0");
        do_load(0, 4, 1'b0, "R2 fill set0 tag1");
        do_load(0, 2, 1'b0, "R2 fill set1 tag0");
        do_load(0, 6, 1'b0, "R2 fill set1 tag1");
        do_load(0, 1, 1'b1, "R2 set0 survives set1 fills");
        do_load(0, 5, 1'b1, "R2 set0 other way");
        do_load(0, 3, 1'b1, "R2 set1 line");
        do_load(0, 7, 1'b1, "R2 set1 other way");
        do_load(0, 8, 1'b0, "R6 conflict miss set0");
        do_load(0, 5, 1'b1, "R6 MRU line kept");
        do_load(0, 0, 1'b0, "R6 LRU line evicted");
        do_load(0, 4, 1'b1, "R6 recently hit line kept");
        do_load(0, 8, 1'b0, "R6 next LRU evicted");
        do_load(0, 3, 1'b1, "R2 set1 untouched by set0 evictions");

        // R5 and R6 on the fully associative instance.
        do_reset();
        for (int k = 0; k < 4; k++) do_load(1, 2 * k, 1'b0, "R5 fill empty ways");
        for (int k = 0; k < 4; k++) do_load(1, 2 * k + 1, 1'b1, "R5 no early eviction");
        do_load(1, 8, 1'b0, "R6 full set miss");
        do_load(1, 2, 1'b1, "R6 younger line kept");
        do_load(1, 0, 1'b0, "R6 oldest line evicted");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule